// File: doc/BRIEF.md
# Descriptor Ring Packet DMA

This block moves Ethernet frames between system memory and a byte-wide MAC stream. It has two channels. The transmit channel reads frames out of memory, and the receive channel writes frames into memory. Each channel follows a circular chain of descriptors. A descriptor is three consecutive 32-bit words: the buffer address at +0, a config/status word at +4, and the address of the next descriptor at +8. Software builds the chain, loads a channel's descriptor pointer, and then sets the channel's enable bit. Ownership passes back and forth through bit 31 of the config word, the "empty" flag. Bits 11:0 of the same word hold the frame length in bytes.

A single sequencer serves one whole frame at a time. When a receive frame is waiting it is served first; otherwise the transmit channel is served. All descriptor and buffer traffic goes through one word-wide memory port with a request/acknowledge handshake. Frame bytes are packed into memory words little-endian: byte n of a frame lands in lane n mod 4 of word n div 4. Each receive buffer holds `BUF_BYTES` bytes, and this parameter must be a multiple of four.

Top module: `dma_ring_engine`

## Requirements
- R1: The register file is selected by a 3-bit index. Index 0 is transmit control (bit 0 = enable). Index 1 is the transmit descriptor pointer. Index 2 is receive control (bit 0 = enable). Index 3 is the receive descriptor pointer. Index 4 is receive status (bit 0 = overflow). After reset all five read 0, and `memReq`, `txValid` and `rxReady` are low.
- R2: When the transmit descriptor's config word has bit 31 clear, the engine sends the number of bytes given in bits 11:0, fetched from the buffer address in little-endian byte order. `txLast` is asserted on the final byte only. While `txValid` is held and `txReady` is low, `txData` and `txLast` stay stable.
- R3: After the last byte of a transmit frame, the engine writes the config word back with bit 31 set and all other bits unchanged. The transmit pointer then reads back the descriptor's next address.
- R4: When the transmit channel reaches a descriptor whose bit 31 is set, it clears its enable bit (index 0 reads 0), sends nothing, and leaves that descriptor unmodified. The pointer stays on that descriptor.
- R5: The receive channel fills a descriptor whose bit 31 is set. It stores the frame bytes little-endian at the buffer address, then writes the config word as the byte count with bit 31 clear, and advances the receive pointer to the next address.
- R6: If the current receive descriptor has bit 31 clear, the engine accepts and discards the whole frame and sets the overflow bit. It writes nothing to memory and does not move the receive pointer.
- R7: If a received frame is longer than `BUF_BYTES`, only the first `BUF_BYTES` bytes are stored. The recorded length is `BUF_BYTES` and memory beyond the buffer is not written.
- R8: Writing 0 to a control register stops that channel. The enable bit keeps reading 1 while a frame is in progress, then reads 0 once that frame is complete. No further descriptor is fetched. A disabled receive channel keeps `rxReady` low.
- R9: Writing 1 to bit 0 of receive status clears the overflow bit.
- R10: A transmit descriptor with length 0 sends no bytes but is still written back with bit 31 set.
- R11: A memory request keeps `memReq`, `memWe` and `memAddr` steady until `memAck`. `memWe` is asserted only with `memReq`. `txValid` and `rxReady` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | ADDR_W | Byte address, word aligned |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory access completes this cycle |
| txData | output | 8 | Transmit byte to MAC |
| txValid | output | 1 | Transmit byte valid |
| txLast | output | 1 | Final byte of the frame |
| txReady | input | 1 | MAC accepts the transmit byte |
| rxData | input | 8 | Received byte from MAC |
| rxValid | input | 1 | Received byte valid |
| rxLast | input | 1 | Final byte of the received frame |
| rxReady | output | 1 | Engine accepts the received byte |

## Verification
The hardest case to reach from the ports is a stop request that arrives while a frame is partway through. To create it, the bench throttles `txReady` to every other cycle, sends a 12-byte frame, and writes 0 to transmit control after the first bytes have gone out. It then checks that the enable bit still reads 1 and that the full frame is completed and handed back. It also checks that the next descriptor in the ring is never fetched, even though software had already marked it as ready to send. Truncation is reached the same way: a 20-byte frame is offered to a 16-byte buffer with a sentinel word placed just past the end of the buffer.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_BUF, S_NXT, S_TXRD, S_TXOUT, S_RXIN, S_RXWR, S_WB, S_DROP
  } seqStateT;

  // which address / data the datapath puts on the memory port
  typedef enum logic [2:0] {
    A_CFG, A_BUF, A_NXT, A_RD, A_WR, A_WB
  } accSelT;

  typedef struct packed {
    logic   rxSel;
    accSelT accSel;
    logic   ldCfg;
    logic   ldBuf;
    logic   ldNext;
    logic   ldWord;
    logic   clrCnt;
    logic   incCnt;
    logic   storeByte;
    logic   advPtr;
    logic   haltTx;
    logic   setOvf;
    logic   txBusy;
    logic   rxBusy;
  } ctlStrobesT;
endpackage

// File: rtl/dma_ring_datapath.sv
module dma_ring_datapath
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int BUF_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  ctlStrobesT        st,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [7:0]        rxData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [7:0]        txData,
  output logic              txEn,
  output logic              rxEn,
  output logic              cfgEmpty,
  output logic              lenZero,
  output logic              lastTxByte,
  output logic              laneLast,
  output logic              bufFull
);
  localparam int EMPTY_BIT = WORD_W - 1;

  logic [ADDR_W-1:0] txPtr, rxPtr, bufAddr, nextAddr, curPtr;
  logic [WORD_W-1:0] cfgReg, wordReg;
  logic [LEN_W-1:0]  cnt, cntM1, frameLen;
  logic              ovf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPtr <= '0; rxPtr <= '0; bufAddr <= '0; nextAddr <= '0;
      cfgReg <= '0; wordReg <= '0; cnt <= '0;
      txEn <= 1'b0; rxEn <= 1'b0; ovf <= 1'b0;
    end else begin
      if (st.ldCfg)  cfgReg   <= memRdata;
      if (st.ldBuf)  bufAddr  <= memRdata[ADDR_W-1:0];
      if (st.ldNext) nextAddr <= memRdata[ADDR_W-1:0];
      if (st.ldWord) wordReg  <= memRdata;
      if (st.storeByte) wordReg[{cnt[1:0], 3'b000} +: 8] <= rxData;
      if (st.clrCnt)      cnt <= '0;
      else if (st.incCnt) cnt <= cnt + LEN_W'(1);
      if (st.haltTx) txEn <= 1'b0;
      if (st.setOvf) ovf  <= 1'b1;
      if (st.advPtr) begin
        if (st.rxSel) rxPtr <= nextAddr;
        else          txPtr <= nextAddr;
      end
      // software writes take precedence over engine updates
      if (regWr) begin
        case (regAddr)
          3'd0: txEn  <= regWdata[0];
          3'd1: txPtr <= regWdata[ADDR_W-1:0];
          3'd2: rxEn  <= regWdata[0];
          3'd3: rxPtr <= regWdata[ADDR_W-1:0];
          3'd4: if (regWdata[0]) ovf <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      3'd0:    regRdata = WORD_W'(txEn | st.txBusy);
      3'd1:    regRdata = WORD_W'(txPtr);
      3'd2:    regRdata = WORD_W'(rxEn | st.rxBusy);
      3'd3:    regRdata = WORD_W'(rxPtr);
      3'd4:    regRdata = WORD_W'(ovf);
      default: regRdata = '0;
    endcase
  end

  assign curPtr   = st.rxSel ? rxPtr : txPtr;
  assign cntM1    = cnt - LEN_W'(1);
  assign frameLen = cfgReg[LEN_W-1:0];

  always_comb begin
    case (st.accSel)
      A_BUF:   memAddr = curPtr;
      A_NXT:   memAddr = curPtr + ADDR_W'(8);
      A_RD:    memAddr = bufAddr + ADDR_W'({cnt[LEN_W-1:2], 2'b00});
      A_WR:    memAddr = bufAddr + ADDR_W'({cntM1[LEN_W-1:2], 2'b00});
      default: memAddr = curPtr + ADDR_W'(4);
    endcase
  end

  always_comb begin
    if (st.accSel == A_WB)
      memWdata = st.rxSel ? WORD_W'(cnt) : (cfgReg | (WORD_W'(1) << EMPTY_BIT));
    else
      memWdata = wordReg;
  end

  assign txData     = wordReg[{cnt[1:0], 3'b000} +: 8];
  assign cfgEmpty   = memRdata[EMPTY_BIT];
  assign lenZero    = (frameLen == '0);
  assign lastTxByte = (cnt == frameLen - LEN_W'(1));
  assign laneLast   = (cnt[1:0] == 2'b11);
  assign bufFull    = (32'(cnt) >= 32'(BUF_BYTES));
endmodule

// File: rtl/dma_ring_ctrl.sv
module dma_ring_ctrl
  import dma_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       rxEn,
  input  logic       cfgEmpty,
  input  logic       lenZero,
  input  logic       lastTxByte,
  input  logic       laneLast,
  input  logic       bufFull,
  input  logic       memAck,
  input  logic       txReady,
  input  logic       rxValid,
  input  logic       rxLast,
  output ctlStrobesT st,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       txLast,
  output logic       rxReady
);
  seqStateT state, nextState;
  logic     rxChan, lastSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; rxChan <= 1'b0; lastSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE) begin
        if (rxEn && rxValid) rxChan <= 1'b1;
        else if (txEn)       rxChan <= 1'b0;
      end
      if (state == S_RXIN && rxValid && !bufFull) lastSeen <= rxLast;
    end
  end

  always_comb begin
    st = '0;
    st.rxSel  = rxChan;
    st.accSel = A_CFG;
    st.txBusy = (state != S_IDLE) && !rxChan;
    st.rxBusy = (state != S_IDLE) && rxChan;
    memReq = 1'b0; memWe = 1'b0;
    txValid = 1'b0; txLast = 1'b0; rxReady = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: if ((rxEn && rxValid) || txEn) nextState = S_CFG;
      S_CFG: begin
        memReq = 1'b1;
        if (memAck) begin
          if (rxChan) begin
            if (cfgEmpty) nextState = S_BUF;
            else begin st.setOvf = 1'b1; nextState = S_DROP; end
          end else if (cfgEmpty) begin
            st.haltTx = 1'b1; nextState = S_IDLE;
          end else begin
            st.ldCfg = 1'b1; nextState = S_BUF;
          end
        end
      end
      S_BUF: begin
        memReq = 1'b1; st.accSel = A_BUF;
        if (memAck) begin st.ldBuf = 1'b1; nextState = S_NXT; end
      end
      S_NXT: begin
        memReq = 1'b1; st.accSel = A_NXT;
        if (memAck) begin
          st.ldNext = 1'b1; st.clrCnt = 1'b1;
          nextState = rxChan ? S_RXIN : (lenZero ? S_WB : S_TXRD);
        end
      end
      S_TXRD: begin
        memReq = 1'b1; st.accSel = A_RD;
        if (memAck) begin st.ldWord = 1'b1; nextState = S_TXOUT; end
      end
      S_TXOUT: begin
        txValid = 1'b1; txLast = lastTxByte;
        if (txReady) begin
          st.incCnt = 1'b1;
          if (lastTxByte)    nextState = S_WB;
          else if (laneLast) nextState = S_TXRD;
        end
      end
      S_RXIN: begin
        rxReady = 1'b1;
        if (rxValid) begin
          if (!bufFull) begin
            st.storeByte = 1'b1; st.incCnt = 1'b1;
            if (rxLast || laneLast) nextState = S_RXWR;
          end else if (rxLast) nextState = S_WB;
        end
      end
      S_RXWR: begin
        memReq = 1'b1; memWe = 1'b1; st.accSel = A_WR;
        if (memAck) nextState = lastSeen ? S_WB : S_RXIN;
      end
      S_WB: begin
        memReq = 1'b1; memWe = 1'b1; st.accSel = A_WB;
        if (memAck) begin st.advPtr = 1'b1; nextState = S_IDLE; end
      end
      S_DROP: begin
        rxReady = 1'b1;
        if (rxValid && rxLast) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
  import dma_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int BUF_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  input  logic              rxLast,
  output logic              rxReady
);
  ctlStrobesT st;
  logic txEn, rxEn, cfgEmpty, lenZero, lastTxByte, laneLast, bufFull;

  dma_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .rxEn(rxEn), .cfgEmpty(cfgEmpty),
    .lenZero(lenZero), .lastTxByte(lastTxByte), .laneLast(laneLast),
    .bufFull(bufFull), .memAck(memAck), .txReady(txReady), .rxValid(rxValid),
    .rxLast(rxLast), .st(st), .memReq(memReq), .memWe(memWe),
    .txValid(txValid), .txLast(txLast), .rxReady(rxReady)
  );

  dma_ring_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .st(st), .memRdata(memRdata),
    .rxData(rxData), .memAddr(memAddr), .memWdata(memWdata), .txData(txData),
    .txEn(txEn), .rxEn(rxEn), .cfgEmpty(cfgEmpty), .lenZero(lenZero),
    .lastTxByte(lastTxByte), .laneLast(laneLast), .bufFull(bufFull)
  );
endmodule

// File: rtl/dma_ring_checker.sv
module dma_ring_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              txValid,
  input logic              txReady,
  input logic              txLast,
  input logic [7:0]        txData,
  input logic              rxReady
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  a_r11_we_in_req: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  a_r11_one_chan: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && rxReady));

  a_r2_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

  a_r2_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast));
endmodule

bind dma_ring_engine dma_ring_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .txValid(txValid), .txReady(txReady), .txLast(txLast),
  .txData(txData), .rxReady(rxReady)
);

// File: tb/dma_ring_engine_tb.sv
module dma_ring_engine_tb;
  localparam int BUFB = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;
  logic [7:0] txData;
  logic txValid, txLast;
  logic txReady = 1'b1;
  logic [7:0] rxData = '0;
  logic rxValid = 1'b0, rxLast = 1'b0;
  logic rxReady;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_ring_engine #(.BUF_BYTES(BUFB)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .txData(txData),
    .txValid(txValid), .txLast(txLast), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .rxLast(rxLast), .rxReady(rxReady)
  );

  // memory model with a backdoor port used by the stimulus
  logic [31:0] mem [256];
  logic bdWe = 1'b0;
  logic [7:0] bdAddr = '0;
  logic [31:0] bdData = '0;
  int wrCount = 0;
  always @(posedge clk) begin
    if (bdWe) mem[bdAddr] <= bdData;
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[memAddr[9:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end else memRdata <= mem[memAddr[9:2]];
    end
  end

  // transmit sink
  logic [7:0] txGot [64];
  int txCnt = 0, lastCnt = 0, lastIdx = -1;
  logic clrTx = 1'b0;
  bit stall = 1'b0;
  always @(posedge clk) begin
    if (clrTx) begin
      txCnt <= 0; lastCnt <= 0; lastIdx <= -1;
    end else if (txValid && txReady) begin
      txGot[txCnt[5:0]] <= txData;
      if (txLast) begin lastCnt <= lastCnt + 1; lastIdx <= txCnt; end
      txCnt <= txCnt + 1;
    end
  end
  always @(negedge clk) txReady <= stall ? ~txReady : 1'b1;

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int widx, input logic [31:0] d);
    @(negedge clk); bdWe = 1'b1; bdAddr = 8'(widx); bdData = d;
    @(negedge clk); bdWe = 1'b0;
  endtask

  task automatic writeReg(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = idx; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk); regAddr = idx; #1; d = regRdata;
  endtask

  task automatic waitReg(input logic [2:0] idx, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    for (int n = 0; n < 2000; n++) begin
      readReg(idx, d);
      if (d == exp) return;
    end
    chkEq(tag, d, exp);
  endtask

  task automatic clearTx();
    @(negedge clk); clrTx = 1'b1;
    @(negedge clk); clrTx = 1'b0;
  endtask

  task automatic rxByte(input logic [7:0] b, input bit last);
    int n;
    rxValid = 1'b1; rxData = b; rxLast = last;
    n = 0;
    while (!rxReady && n < 500) begin @(negedge clk); n++; end
    if (n >= 500) chkEq("R5 rx byte accepted", 32'(rxReady), 32'd1);
    @(negedge clk);
  endtask

  task automatic rxFrame(input int len, input logic [7:0] base);
    @(negedge clk);
    for (int k = 0; k < len; k++) rxByte(base + 8'(k), k == len - 1);
    rxValid = 1'b0; rxLast = 1'b0;
  endtask

  function automatic logic [7:0] txPat(input int k);
    return 8'(k * 13 + 5);
  endfunction

  // stimulus table: frame length, throttle txReady
  localparam int NVEC = 5;
  localparam int TX_VEC [NVEC][2] = '{'{1, 0}, '{4, 1}, '{5, 0}, '{11, 1}, '{0, 0}};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int snap;
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 5; i++) begin
      readReg(3'(i), d);
      chkEq("R1 register reset", d, 32'd0);
    end
    chkEq("R1 memReq reset", 32'(memReq), 32'd0);
    chkEq("R1 txValid reset", 32'(txValid), 32'd0);
    chkEq("R1 rxReady reset", 32'(rxReady), 32'd0);
    @(negedge clk); rstN = 1'b1;

    for (int w = 0; w < 4; w++)
      poke(64 + w, {txPat(4*w+3), txPat(4*w+2), txPat(4*w+1), txPat(4*w)});

    // table walk: one frame per vector, ring halts on the following empty slot
    for (int v = 0; v < NVEC; v++) begin
      int len;
      len = TX_VEC[v][0];
      stall = TX_VEC[v][1] != 0;
      poke(0, 32'h100); poke(1, 32'(len)); poke(2, 32'h10);
      poke(4, 32'h100); poke(5, 32'h8000_0000); poke(6, 32'h0);
      clearTx();
      writeReg(3'd1, 32'h0);
      writeReg(3'd0, 32'h1);
      waitReg(3'd0, 32'h0, "R4 tx halts");
      repeat (2) @(negedge clk);
      chkEq(len == 0 ? "R10 zero length byte count" : "R2 byte count", 32'(txCnt), 32'(len));
      for (int k = 0; k < len; k++) chkEq("R2 byte value", 32'(txGot[k]), 32'(txPat(k)));
      if (len > 0) begin
        chkEq("R2 single txLast", 32'(lastCnt), 32'd1);
        chkEq("R2 txLast on final byte", 32'(lastIdx), 32'(len - 1));
      end
      chkEq(len == 0 ? "R10 zero length writeback" : "R3 writeback empty set",
            mem[1], 32'h8000_0000 | 32'(len));
      readReg(3'd1, d);
      chkEq("R3 pointer follows next", d, 32'h10);
      chkEq("R4 empty slot untouched", mem[5], 32'h8000_0000);
    end
    stall = 1'b0;

    // R8: stop while a throttled frame is in flight
    poke(16, 32'h100); poke(17, 32'd12); poke(18, 32'h50);
    poke(20, 32'h100); poke(21, 32'd2);  poke(22, 32'h40);
    clearTx();
    stall = 1'b1;
    writeReg(3'd1, 32'h40);
    writeReg(3'd0, 32'h1);
    while (txCnt < 2) @(negedge clk);
    writeReg(3'd0, 32'h0);
    readReg(3'd0, d);
    chkEq("R8 enable reads 1 mid frame", d, 32'h1);
    waitReg(3'd0, 32'h0, "R8 enable reads 0 after frame");
    repeat (30) @(negedge clk);
    chkEq("R8 frame completed", 32'(txCnt), 32'd12);
    chkEq("R8 frame handed back", mem[17], 32'h8000_000C);
    chkEq("R8 next descriptor not used", mem[21], 32'd2);
    readReg(3'd1, d);
    chkEq("R8 pointer after stop", d, 32'h50);
    stall = 1'b0;

    // R5: receive into an empty descriptor
    for (int w = 128; w < 132; w++) poke(w, 32'hDEAD_BEEF);
    for (int w = 160; w < 165; w++) poke(w, 32'hDEAD_BEEF);
    poke(8, 32'h200);  poke(9, 32'h8000_0000); poke(10, 32'h30);
    poke(12, 32'h280); poke(13, 32'h0);        poke(14, 32'h20);
    writeReg(3'd3, 32'h20);
    writeReg(3'd2, 32'h1);
    rxFrame(6, 8'h40);
    waitReg(3'd3, 32'h30, "R5 rx pointer advances");
    chkEq("R5 rx length written", mem[9], 32'd6);
    chkEq("R5 rx word 0", mem[128], 32'h4342_4140);
    chkEq("R5 rx word 1 low bytes", {16'h0, mem[129][15:0]}, 32'h0000_4544);

    // R6: current descriptor still owned by software
    snap = wrCount;
    rxFrame(3, 8'h50);
    repeat (6) @(negedge clk);
    readReg(3'd4, d);
    chkEq("R6 overflow set", d, 32'h1);
    readReg(3'd3, d);
    chkEq("R6 pointer kept", d, 32'h30);
    chkEq("R6 no memory write", 32'(wrCount), 32'(snap));
    chkEq("R6 descriptor untouched", mem[13], 32'h0);

    // R9: clear overflow
    writeReg(3'd4, 32'h1);
    readReg(3'd4, d);
    chkEq("R9 overflow cleared", d, 32'h0);

    // R7: truncation to the buffer size
    poke(13, 32'h8000_0000);
    rxFrame(20, 8'h60);
    waitReg(3'd3, 32'h20, "R7 rx pointer wraps");
    chkEq("R7 length capped", mem[13], 32'(BUFB));
    for (int w = 0; w < 4; w++)
      chkEq("R7 stored word", mem[160 + w],
            {8'h60 + 8'(4*w+3), 8'h60 + 8'(4*w+2), 8'h60 + 8'(4*w+1), 8'h60 + 8'(4*w)});
    chkEq("R7 beyond buffer untouched", mem[164], 32'hDEAD_BEEF);

    // R8: disabled receive channel holds off the MAC
    writeReg(3'd2, 32'h0);
    readReg(3'd2, d);
    chkEq("R8 rx enable reads 0", d, 32'h0);
    @(negedge clk); rxValid = 1'b1; rxData = 8'h11; rxLast = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chkEq("R8 rxReady low when disabled", 32'(rxReady), 32'd0);
    end
    rxValid = 1'b0; rxLast = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule